// File: doc/BRIEF.md
# Time-Base Divider with Programmable Periodic Rate

This block counts a slow time-base, given as a one-cycle clock enable on the system clock, through a binary divider chain. When the chain wraps it emits a one-second tick for the update logic that follows it. The same chain feeds a bank of taps, and a four-bit rate code picks one of them. Each rising edge of the chosen tap gives a one-cycle periodic event pulse, which goes on to the interrupt flag logic.

A three-bit mode field either lets the chain run or holds it at the midpoint of its one-second span. This allows the time to be set exactly: after the field is set back to the run value, the first tick comes half a second later. The periodic event always fires. A second output, the interrupt request, only follows the event when the periodic enable bit is set.

Top module: `rtc_divrate`

## Requirements
- R1: While `rst_n` is low, `sec_tick`, `per_evt` and `per_irq` are 0, and the chain is loaded with its midpoint value 2^(CNT_W-1).
- R2: Only `div_ctl` = 3'b010 lets the chain run. All other seven values hold it at the midpoint, and while it is held neither `sec_tick` nor `per_evt` pulses.
- R3: After `div_ctl` goes to 3'b010, the first `sec_tick` follows the 16384th accepted time-base enable, which is half of the 32768-enable second.
- R4: After the first tick, `sec_tick` pulses once every 32768 accepted enables.
- R5: `sec_tick` is high for exactly one clock. It appears in the clock cycle that follows the edge which accepted the enable.
- R6: For rate code n from 3 to 15, `per_evt` is a one-clock pulse every 2^(n-1) enables. After release, the first pulse comes after 2^(n-2) enables.
- R7: Rate code 0 produces no `per_evt` pulse.
- R8: Rate codes 1 and 2 behave exactly like codes 8 and 9.
- R9: `per_irq` pulses together with `per_evt` when `per_en` is 1, and stays 0 when `per_en` is 0. `per_evt` does not depend on `per_en`.
- R10: Changing `rate_sel` while the chain runs produces no extra pulse. The next `per_evt` comes at the next rising edge of the newly selected tap.
- R11: A cycle with `tb_en` low does not advance the chain and produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tb_en | input | 1 | One-cycle enable for each time-base period |
| div_ctl | input | 3 | Mode: 3'b010 runs the chain, any other value holds it |
| rate_sel | input | 4 | Periodic rate code |
| per_en | input | 1 | Lets the periodic event raise the interrupt request |
| sec_tick | output | 1 | One-clock pulse each second |
| per_evt | output | 1 | One-clock periodic event pulse |
| per_irq | output | 1 | Periodic event gated by `per_en` |

## Verification
The bench steps through every rate code, including the two alias codes, starting from a fresh release each time. It measures both the delay to the first event and the spacing to the second. An off-by-one tap shows up as a doubled or halved spacing, and a wrong preload shows up in the first delay. Separate runs cover the following cases: all seven hold values of the mode field; a gap in the enables in the middle of the first half-second; a rate switch placed where the new tap is already high, which exposes a naive edge detector; and the enable bit for the request, both on and off.

// File: rtl/rtc_divrate_pkg.sv
package rtc_divrate_pkg;

  localparam logic [2:0] DIV_RUN = 3'b010;

  // Codes 1 and 2 reuse the taps of codes 8 and 9.
  function automatic logic [3:0] eff_code(input logic [3:0] code);
    case (code)
      4'd1:    eff_code = 4'd8;
      4'd2:    eff_code = 4'd9;
      default: eff_code = code;
    endcase
  endfunction

  // Code n picks tap bit n-2; codes below 3 pick nothing.
  function automatic logic tap_valid(input logic [3:0] eff);
    tap_valid = (eff >= 4'd3);
  endfunction

endpackage

// File: rtl/rtc_chain.sv
module rtc_chain #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tb_en,
  input  logic             run,
  output logic [CNT_W-1:0] cnt,
  output logic             adv,
  output logic             sec_tick
);
  localparam logic [CNT_W-1:0] HALF = {1'b1, {(CNT_W-1){1'b0}}};

  logic wrap;

  assign adv  = tb_en && run;
  assign wrap = adv && (&cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= HALF;
      sec_tick <= 1'b0;
    end else begin
      sec_tick <= wrap;
      if (!run)      cnt <= HALF;
      else if (adv)  cnt <= cnt + 1'b1;
    end
  end

  AST_HOLD_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == HALF && !sec_tick));                      // R2
  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> !sec_tick);                                    // R5
  AST_TICK_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |-> (cnt == '0 || cnt == HALF));                   // R4
  AST_IDLE_NO_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    (!tb_en && run) |=> ($stable(cnt) && !sec_tick));          // R11
endmodule

// File: rtl/rtc_rate_tap.sv
module rtc_rate_tap
  import rtc_divrate_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             adv,
  input  logic [3:0]       rate_sel,
  input  logic             per_en,
  output logic             per_evt,
  output logic             per_irq
);
  localparam int NTAP = CNT_W - 1;

  logic [NTAP-1:0] rise;
  logic [3:0]      eff;
  logic [3:0]      tap_idx;
  logic            sel_rise;

  // Bit k rises on this increment when the low bits read 0 followed by k ones.
  for (genvar k = 0; k < NTAP; k++) begin : g_tap
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] MSK = (ONE << (k + 1)) - ONE;
    localparam logic [CNT_W-1:0] PAT = (ONE << k) - ONE;
    assign rise[k] = ((cnt & MSK) == PAT);
  end

  assign eff     = eff_code(rate_sel);
  assign tap_idx = eff - 4'd2;

  always_comb begin
    sel_rise = 1'b0;
    if (adv && tap_valid(eff) && (int'(tap_idx) < NTAP))
      sel_rise = rise[tap_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_evt <= 1'b0;
      per_irq <= 1'b0;
    end else begin
      per_evt <= sel_rise;
      per_irq <= sel_rise && per_en;
    end
  end

  AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    per_evt |=> !per_evt);                                      // R6
  AST_CODE0_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel == 4'd0) |=> !per_evt);                           // R7
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    per_irq |-> per_evt);                                       // R9
  AST_EVT_NEEDS_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> !per_evt);                                         // R11
endmodule

// File: rtl/rtc_divrate.sv
module rtc_divrate
  import rtc_divrate_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tb_en,
  input  logic [2:0] div_ctl,
  input  logic [3:0] rate_sel,
  input  logic       per_en,
  output logic       sec_tick,
  output logic       per_evt,
  output logic       per_irq
);
  logic             run;
  logic             adv;
  logic [CNT_W-1:0] cnt;

  assign run = (div_ctl == DIV_RUN);

  rtc_chain #(.CNT_W(CNT_W)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .tb_en    (tb_en),
    .run      (run),
    .cnt      (cnt),
    .adv      (adv),
    .sec_tick (sec_tick)
  );

  rtc_rate_tap #(.CNT_W(CNT_W)) u_tap (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt      (cnt),
    .adv      (adv),
    .rate_sel (rate_sel),
    .per_en   (per_en),
    .per_evt  (per_evt),
    .per_irq  (per_irq)
  );

  AST_HOLD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!per_evt && !sec_tick));                          // R2
endmodule

// File: tb/tb_rtc_divrate.sv
module tb_rtc_divrate;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tb_en = 1'b0;
  logic [2:0] div_ctl = 3'b000;
  logic [3:0] rate_sel = 4'd0;
  logic       per_en = 1'b0;
  logic       sec_tick, per_evt, per_irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  rtc_divrate dut (
    .clk(clk), .rst_n(rst_n), .tb_en(tb_en), .div_ctl(div_ctl),
    .rate_sel(rate_sel), .per_en(per_en),
    .sec_tick(sec_tick), .per_evt(per_evt), .per_irq(per_irq)
  );

  // code, enables to first event after release, spacing of events
  localparam int VEC [15][3] = '{
    '{3, 2, 4},        '{4, 4, 8},        '{5, 8, 16},
    '{6, 16, 32},      '{7, 32, 64},      '{8, 64, 128},
    '{9, 128, 256},    '{10, 256, 512},   '{11, 512, 1024},
    '{12, 1024, 2048}, '{13, 2048, 4096}, '{14, 4096, 8192},
    '{15, 8192, 16384},'{1, 64, 128},     '{2, 128, 256}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Counts posedges until the chosen output is seen high at a negedge.
  task automatic wait_pulse(input int which, input int limit, output int n);
    logic seen;
    n = 0;
    seen = 1'b0;
    while (!seen && n < limit) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      case (which)
        0: seen = per_evt;
        1: seen = sec_tick;
        default: seen = per_irq;
      endcase
    end
  endtask

  task automatic hold_then_release(input logic [3:0] code);
    @(negedge clk);
    div_ctl  = 3'b000;
    rate_sel = code;
    tb_en    = 1'b1;
    repeat (3) @(negedge clk);
    div_ctl = 3'b010;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected below 190000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int n;
    int ev, iq;
    logic [2:0] holds [7];
    holds = '{3'b000, 3'b001, 3'b011, 3'b100, 3'b101, 3'b110, 3'b111};

    // R1: reset state, even with run mode and enables applied
    div_ctl = 3'b010; tb_en = 1'b1; rate_sel = 4'd3; per_en = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk("R1 outputs in reset", {29'd0, sec_tick, per_evt, per_irq}, 0);
    end
    div_ctl = 3'b000;
    @(negedge clk);
    rst_n = 1'b1;

    // R2: every hold value keeps the outputs quiet
    for (int h = 0; h < 7; h++) begin
      @(negedge clk);
      div_ctl = holds[h];
      ev = 0;
      repeat (20) begin
        @(negedge clk);
        ev += int'(per_evt) + int'(sec_tick);
      end
      chk($sformatf("R2 pulses in hold %0d", holds[h]), ev, 0);
    end

    // R3 and R11: first tick after release, with a gap in the enables
    hold_then_release(4'd3);
    repeat (100) @(negedge clk);
    tb_en = 1'b0;
    ev = 0;
    repeat (60) begin
      @(negedge clk);
      ev += int'(per_evt) + int'(sec_tick);
    end
    chk("R11 pulses while tb_en low", ev, 0);
    tb_en = 1'b1;
    wait_pulse(1, 20000, n);
    chk("R3 enables to first tick", n + 100, 16384);

    // R5: a single-clock pulse; R4: the next tick a full second later
    @(posedge clk); @(negedge clk);
    chk("R5 tick width", int'(sec_tick), 0);
    wait_pulse(1, 40000, n);
    chk("R4 tick spacing", n + 1, 32768);

    // R6 and R8: every code from a fresh release (R7 for code 0 below)
    for (int v = 0; v < 15; v++) begin
      hold_then_release(VEC[v][0][3:0]);
      wait_pulse(0, VEC[v][1] + 8, n);
      chk($sformatf("%s first event code %0d", (v > 12) ? "R8" : "R6", VEC[v][0]),
          n, VEC[v][1]);
      wait_pulse(0, VEC[v][2] + 8, n);
      chk($sformatf("%s spacing code %0d", (v > 12) ? "R8" : "R6", VEC[v][0]),
          n, VEC[v][2]);
    end

    // R7: code 0 gives no event while running
    hold_then_release(4'd0);
    ev = 0;
    repeat (300) begin
      @(negedge clk);
      ev += int'(per_evt);
    end
    chk("R7 events with code 0", ev, 0);

    // R9: request follows the event only with per_en set
    hold_then_release(4'd3);
    per_en = 1'b1;
    ev = 0; iq = 0;
    repeat (40) begin
      @(negedge clk);
      ev += int'(per_evt);
      iq += int'(per_irq && per_evt);
    end
    chk("R9 events with enable", ev, 10);
    chk("R9 requests with enable", iq, 10);
    per_en = 1'b0;
    ev = 0; iq = 0;
    repeat (40) begin
      @(negedge clk);
      ev += int'(per_evt);
      iq += int'(per_irq);
    end
    chk("R9 events without enable", ev, 10);
    chk("R9 requests without enable", iq, 0);

    // R10: switch from code 3 to code 4 when bit 2 is already high
    hold_then_release(4'd3);
    repeat (4) @(negedge clk);
    rate_sel = 4'd4;
    wait_pulse(0, 40, n);
    chk("R10 first event after rate change", n, 8);
    wait_pulse(0, 40, n);
    chk("R10 spacing after rate change", n, 8);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule